// File: doc/BRIEF.md
# Dual-Law Serial Clock Divider

This block derives the serial clock of a serial-peripheral master from the module clock. A 13-bit configuration word carries two divider fields and a select bit. The select bit picks one of two division laws. The linear law gives an even ratio of 2×(N+1) for an 8-bit N. The power-of-two law gives a ratio of 2^N for a 4-bit N. The linear law covers ratios up to 512. Slower clocks need the power-of-two law.

A `run` input is held high for the whole of a transfer. While `run` is high, the block toggles `sclk` once every half period. With each toggle it raises a one-cycle strobe: `lead_stb` when the clock leaves its idle level and `trail_stb` when it returns. The shift engine uses these strobes to launch and capture bits. While `run` is low, `sclk` rests at the level given by `cpol`, and the block keeps re-sampling the configuration word and `cpol`. Those values are then frozen for the duration of the next transfer.

The block has no data stream, so it has no valid/ready handshake. All of its pins are plain control and status levels. There is no back-pressure. The consumer must act on each strobe in the cycle it is presented.

Top module: `spi_clkdiv_dual`

## Requirements
- R1: While `run` is sampled low at a clock edge, `sclk` equals the `cpol` value sampled at that edge after the edge, and neither strobe is high.
- R2: When `div_cfg[12]` is 1 (linear law), with N = `div_cfg[7:0]`, `sclk` toggles every N+1 module clock cycles. This gives a period of 2×(N+1) cycles. N=255 gives the maximum ratio of 512.
- R3: When `div_cfg[12]` is 0 (power-of-two law) and N = `div_cfg[11:8]` is at least 1, `sclk` toggles every 2^(N-1) cycles. This gives a period of 2^N cycles.
- R4: With the power-of-two law and N=0, the block produces an edge on every module clock cycle. This is the same as N=1, because the registered output cannot run faster than half the module clock.
- R5: The half-period counter restarts when `run` rises. The first toggle appears H clock edges after `run` goes high, where H is the half period in cycles.
- R6: `lead_stb` is high for exactly the cycle in which `sclk` first leaves its idle level. `trail_stb` is high for the cycle in which `sclk` returns to it. The strobes alternate, starting with `lead_stb`, with H cycles between them, so the duty cycle is 50%.
- R7: A strobe is only ever high in a cycle that follows an edge at which `run` was high. The two strobes are never high together.
- R8: `div_cfg` and `cpol` are captured only while idle. Changing them while `run` is high alters neither the toggle spacing nor the idle level used by the strobes until the next transfer.
- R9: During reset, `sclk`, `lead_stb` and `trail_stb` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_cfg | input | 13 | [12] law select (1 linear, 0 power-of-two), [11:8] power exponent, [7:0] linear count |
| run | input | 1 | High for the duration of a transfer |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle pulse when `sclk` leaves idle |
| trail_stb | output | 1 | One-cycle pulse when `sclk` returns to idle |

## Verification
Different faults show at different times. A corrupted terminal count or a counter that fails to restart shows up as a wrong spacing of the very first strobe after `run` rises, so it is caught within one half period. A wrong idle-level shadow swaps `lead_stb` and `trail_stb` on the first toggle. A config register that follows the input during a transfer changes the spacing of the next strobe. A broken idle path leaves `sclk` away from `cpol` one cycle after `run` falls.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;

  typedef enum logic {
    LAW_POW2   = 1'b0,
    LAW_LINEAR = 1'b1
  } div_law_e;

  // Width of the half-period terminal count for the two laws
  function automatic int unsigned term_width(input int unsigned lin_w, input int unsigned pow_w);
    int unsigned pw;
    pw = (2 ** pow_w) - 2;
    if (pw < 1) pw = 1;
    return (lin_w > pw) ? lin_w : pw;
  endfunction

endpackage

// File: rtl/spi_clkdiv_cfg.sv
module spi_clkdiv_cfg
  import spi_clkdiv_pkg::*;
#(
  parameter int unsigned LIN_W = 8,
  parameter int unsigned POW_W = 4,
  parameter int unsigned CNT_W = term_width(LIN_W, POW_W),
  localparam int unsigned CFG_W = LIN_W + POW_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic [CFG_W-1:0] cfg_in,
  input  logic             cpol_in,
  output logic [CNT_W-1:0] term_q,
  output logic             idle_lvl_q
);

  localparam int unsigned WIDE_W = CNT_W + 1;

  div_law_e             law;
  logic [LIN_W-1:0]     lin_n;
  logic [POW_W-1:0]     pow_n;
  logic [WIDE_W-1:0]    pow_half;
  logic [CNT_W-1:0]     term_d;

  assign law   = div_law_e'(cfg_in[CFG_W-1]);
  assign lin_n = cfg_in[LIN_W-1:0];
  assign pow_n = cfg_in[LIN_W +: POW_W];

  // half period of the power law: 2^(N-1), with N=0 clamped to 1
  always_comb begin
    if (pow_n == '0) pow_half = WIDE_W'(1);
    else             pow_half = WIDE_W'(1) << (pow_n - POW_W'(1));
  end

  always_comb begin
    if (law == LAW_LINEAR) term_d = CNT_W'(lin_n);
    else                   term_d = CNT_W'(pow_half - WIDE_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_q     <= '0;
      idle_lvl_q <= 1'b0;
    end else if (idle) begin
      term_q     <= term_d;
      idle_lvl_q <= cpol_in;
    end
  end

endmodule

// File: rtl/spi_clkdiv_cnt.sv
module spi_clkdiv_cnt #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] term,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q;

  assign tick = run && (cnt_q == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (!run)  cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/spi_clkdiv_edge.sv
module spi_clkdiv_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic cpol_live,
  input  logic idle_lvl,
  output logic sclk_q,
  output logic lead_q,
  output logic trail_q
);

  logic leaving;

  assign leaving = (sclk_q == idle_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (!run) begin
      sclk_q  <= cpol_live;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      lead_q  <= tick && leaving;
      trail_q <= tick && !leaving;
      if (tick) sclk_q <= ~sclk_q;
    end
  end

endmodule

// File: rtl/spi_clkdiv_dual.sv
module spi_clkdiv_dual
  import spi_clkdiv_pkg::*;
#(
  parameter int unsigned LIN_W = 8,
  parameter int unsigned POW_W = 4,
  localparam int unsigned CFG_W = LIN_W + POW_W + 1,
  localparam int unsigned CNT_W = term_width(LIN_W, POW_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] div_cfg,
  input  logic             run,
  input  logic             cpol,
  output logic             sclk,
  output logic             lead_stb,
  output logic             trail_stb
);

  logic [CNT_W-1:0] term;
  logic             idle_lvl;
  logic             tick;

  spi_clkdiv_cfg #(
    .LIN_W (LIN_W),
    .POW_W (POW_W),
    .CNT_W (CNT_W)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle       (!run),
    .cfg_in     (div_cfg),
    .cpol_in    (cpol),
    .term_q     (term),
    .idle_lvl_q (idle_lvl)
  );

  spi_clkdiv_cnt #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .term  (term),
    .tick  (tick)
  );

  spi_clkdiv_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick      (tick),
    .cpol_live (cpol),
    .idle_lvl  (idle_lvl),
    .sclk_q    (sclk),
    .lead_q    (lead_stb),
    .trail_q   (trail_stb)
  );

endmodule

// File: rtl/spi_clkdiv_chk.sv
module spi_clkdiv_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic cpol,
  input logic sclk,
  input logic lead_stb,
  input logic trail_stb
);

  // R1
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (sclk == $past(cpol)) && !lead_stb && !trail_stb);

  // R7
  strobe_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_stb || trail_stb) |-> $past(run));

  // R7
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_stb && trail_stb));

  // R6
  strobe_marks_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) |-> ((lead_stb || trail_stb) == (sclk != $past(sclk))));

  // R9
  always_comb begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!sclk && !lead_stb && !trail_stb);
    end
  end

endmodule

bind spi_clkdiv_dual spi_clkdiv_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .cpol      (cpol),
  .sclk      (sclk),
  .lead_stb  (lead_stb),
  .trail_stb (trail_stb)
);

// File: tb/tb_spi_clkdiv_dual.sv
module tb_spi_clkdiv_dual;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] div_cfg = '0;
  logic        run = 1'b0;
  logic        cpol = 1'b0;
  logic        sclk, lead_stb, trail_stb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  spi_clkdiv_dual dut (
    .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .run(run), .cpol(cpol),
    .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  // {law[28], lin[27:20], pow[19:16], cpol[15], expected half period[14:0]}
  localparam int NV = 10;
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 8'd0,   4'd0,  1'b0, 15'd1},
    {1'b1, 8'd3,   4'd0,  1'b1, 15'd4},
    {1'b1, 8'd17,  4'd9,  1'b0, 15'd18},
    {1'b1, 8'd255, 4'd0,  1'b1, 15'd256},
    {1'b0, 8'd0,   4'd0,  1'b0, 15'd1},
    {1'b0, 8'd77,  4'd1,  1'b1, 15'd1},
    {1'b0, 8'd0,   4'd3,  1'b1, 15'd4},
    {1'b0, 8'd5,   4'd6,  1'b0, 15'd32},
    {1'b0, 8'd0,   4'd12, 1'b1, 15'd2048},
    {1'b0, 8'd0,   4'd15, 1'b0, 15'd16384}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // count negedges until the wanted strobe; the other strobe must not appear first
  task automatic wait_strobe(input bit want_lead, input int limit, output int k);
    k = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      k++;
      if (want_lead ? lead_stb : trail_stb) return;
      if (lead_stb || trail_stb) begin
        k = -1;
        return;
      end
    end
    k = -2;
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int k;
    string req;
    // R9 reset state
    repeat (3) @(negedge clk);
    check(!sclk && !lead_stb && !trail_stb, "R9 reset outputs", {sclk, lead_stb, trail_stb}, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      int h;
      bit cp;
      h  = int'(VEC[v][14:0]);
      cp = VEC[v][15];
      req = VEC[v][28] ? "R2" : ((VEC[v][19:16] == 4'd0) ? "R4" : "R3");
      div_cfg = {VEC[v][28], VEC[v][19:16], VEC[v][27:20]};
      cpol    = cp;
      repeat (2) @(negedge clk);
      check(sclk == cp && !lead_stb && !trail_stb, "R1 idle level", sclk, cp);
      run = 1'b1;
      wait_strobe(1'b1, 40000, k);
      check(k == h, "R5 first edge delay", k, h);
      check(sclk == !cp, "R6 lead leaves idle", sclk, !cp);
      wait_strobe(1'b0, 40000, k);
      check(k == h, {req, " half period lead-trail"}, k, h);
      check(sclk == cp, "R6 trail returns idle", sclk, cp);
      wait_strobe(1'b1, 40000, k);
      check(k == h, {req, " half period trail-lead"}, k, h);
      run = 1'b0;
      @(negedge clk);
      check(sclk == cp && !lead_stb && !trail_stb, "R7 quiet after run falls", sclk, cp);
    end

    // R8: config and polarity changes during a transfer are ignored
    div_cfg = {1'b1, 4'd0, 8'd1};
    cpol = 1'b0;
    repeat (2) @(negedge clk);
    run = 1'b1;
    wait_strobe(1'b1, 100, k);
    check(k == 2, "R8 first edge", k, 2);
    div_cfg = {1'b1, 4'd0, 8'd9};
    cpol = 1'b1;
    wait_strobe(1'b0, 100, k);
    check(k == 2, "R8 spacing unchanged", k, 2);
    check(sclk == 1'b0, "R8 idle level unchanged", sclk, 0);
    run = 1'b0;
    @(negedge clk);
    check(sclk == 1'b1, "R1 new cpol when idle", sclk, 1);

    // R5: restart mid half-period resets the counter
    div_cfg = {1'b1, 4'd0, 8'd7};
    cpol = 1'b0;
    repeat (2) @(negedge clk);
    run = 1'b1;
    repeat (5) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    run = 1'b1;
    wait_strobe(1'b1, 100, k);
    check(k == 8, "R5 restart delay", k, 8);
    run = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule